// File: doc/BRIEF.md
# Store ordering buffer

This block sits beside the load path of an out-of-order core. It holds the stores that are still in flight and, for every load that asks, returns one verdict: read the data cache, take the data forwarded from a buffered store, or wait. Stores are entered in program order and each gets a slot index. The store's word address with its byte enables, and its data, arrive later through two separate write operations. These two operations are independent and either can come first.

A load carries a tag. The tag is the extended index of the youngest store allocated before the load. Only stores from the oldest buffered entry up to that tag are compared with the load. A blocked load gets back the slot that blocks it and the cause. The buffer then sends a wake pulse for that slot when the address arrives, when the data arrives, or when the entry drains. This lets the load pipeline re-issue the load at the right time.

A retire pulse marks the oldest non-retired store as retired. A small drain state machine then writes the retired stores to the cache one at a time, in order, and only when the cache reports its write port idle. A flush drops every store that has not retired. Retired stores stay in the buffer and still drain.

Top module: `store_order_buf`

## Requirements
- R1: After reset the buffer is empty: `st_full` is 0, `st_alloc_tag` is 0, and no response, wake or cache write is asserted.
- R2: Each accepted allocation takes slot `st_alloc_tag[IW-1:0]` and advances the extended tag by one, wrapping. With NUM_ENT stores held, `st_full` is 1 and a further allocation is ignored, so the tag does not change.
- R3: A load is compared only with the valid entries from the oldest one through its tag. Younger stores are ignored. A tag that is older than the oldest entry selects no entry.
- R4: If any compared store has no address yet, the response is block (kind 2) with cause 1. It names the oldest such slot.
- R5: Otherwise, the nearest compared store with the same word address and at least one common byte enable is the match. If the match has no data yet, the response is block with cause 2 and names the match's slot.
- R6: If the match has data and its byte enables cover every byte enable of the load, the response is forward (kind 1) and carries the store's whole data word. Each response appears exactly one cycle after its load request.
- R7: If the match has data but does not cover all of the load's bytes, the response is block with cause 3 and names the match's slot.
- R8: With no unresolved address and no match, the response is cache (kind 0) with cause 0.
- R9: Address and data writes may come in either order. Each write raises its own wake output one cycle later, carrying the slot it wrote.
- R10: Each retire pulse marks the oldest non-retired store as retired. Retired stores are written to the cache oldest first. Each write frees its slot, and the freed slot index appears on `wake_free_idx` one cycle later.
- R11: A flush discards all non-retired stores, and the next allocation reuses the first discarded slot. Retired stores stay in place, still forward to loads, and still drain.
- R12: The drain state machine moves from DRAIN_IDLE to DRAIN_WRITE only when a retired store is present and `cache_idle` is high. It spends exactly one cycle in DRAIN_WRITE, which is the only cycle `cache_wr_valid` is high, and then returns to DRAIN_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_alloc | input | 1 | Allocate a store slot |
| st_alloc_tag | output | IW+1 | Extended index the next allocated store receives |
| st_full | output | 1 | All slots are in use |
| st_addr_valid | input | 1 | Write the address and byte enables of a slot |
| st_addr_idx | input | IW | Slot for the address write |
| st_addr | input | ADDR_W | Store word address |
| st_be | input | BW | Store byte enables |
| st_data_valid | input | 1 | Write the data of a slot |
| st_data_idx | input | IW | Slot for the data write |
| st_data | input | DATA_W | Store data |
| st_retire | input | 1 | Retire the oldest non-retired store |
| flush | input | 1 | Discard all non-retired stores |
| ld_valid | input | 1 | Load lookup request |
| ld_tag | input | IW+1 | Extended index of the youngest older store |
| ld_addr | input | ADDR_W | Load word address |
| ld_be | input | BW | Load byte enables |
| ld_rsp_valid | output | 1 | Response valid |
| ld_rsp_kind | output | 2 | 0 cache, 1 forward, 2 block |
| ld_rsp_cause | output | 2 | 0 none, 1 address, 2 data, 3 partial |
| ld_rsp_idx | output | IW | Blocking slot |
| ld_rsp_data | output | DATA_W | Forwarded data |
| wake_addr_valid | output | 1 | An address was written |
| wake_addr_idx | output | IW | Slot of that address write |
| wake_data_valid | output | 1 | Data was written |
| wake_data_idx | output | IW | Slot of that data write |
| wake_free_valid | output | 1 | A slot drained |
| wake_free_idx | output | IW | Drained slot |
| cache_idle | input | 1 | Cache write port idle |
| cache_wr_valid | output | 1 | Cache write strobe |
| cache_wr_addr | output | ADDR_W | Cache write word address |
| cache_wr_be | output | BW | Cache write byte enables |
| cache_wr_data | output | DATA_W | Cache write data |

## Verification
The bench builds the block with its default parameters: eight slots, 16-bit word addresses and 32-bit data. Eight slots are enough to hold four live stores whose address and data arrive in different orders. They also let the tag wrap past the slot count after a flush and a drain, and let the bench fill the buffer completely starting from a non-zero head. With four-byte enables the bench can build partial overlaps, fully covered loads and loads whose bytes miss the nearest store.

// File: rtl/sob_pkg.sv
package sob_pkg;
    typedef enum logic [1:0] {
        RSP_CACHE = 2'd0,
        RSP_FWD   = 2'd1,
        RSP_BLOCK = 2'd2
    } rsp_kind_e;

    typedef enum logic [1:0] {
        CS_NONE = 2'd0,
        CS_ADDR = 2'd1,
        CS_DATA = 2'd2,
        CS_PART = 2'd3
    } blk_cause_e;

    typedef enum logic [0:0] {
        DRAIN_IDLE  = 1'b0,
        DRAIN_WRITE = 1'b1
    } drain_state_e;
endpackage

// File: rtl/sob_entries.sv
module sob_entries #(
    parameter int NUM_ENT = 8,
    parameter int AW = 16,
    parameter int DW = 32,
    localparam int IW = $clog2(NUM_ENT),
    localparam int BW = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [IW-1:0]    alloc_pos,
    input  logic             addr_we,
    input  logic [IW-1:0]    addr_pos,
    input  logic [AW-1:0]    addr_in,
    input  logic [BW-1:0]    be_in,
    input  logic             data_we,
    input  logic [IW-1:0]    data_pos,
    input  logic [DW-1:0]    data_in,
    input  logic             retire_en,
    input  logic [IW-1:0]    retire_pos,
    input  logic             free_en,
    input  logic [IW-1:0]    free_pos,
    input  logic             flush_en,
    output logic [NUM_ENT-1:0] vld,
    output logic [NUM_ENT-1:0] sen,
    output logic [NUM_ENT-1:0] av,
    output logic [NUM_ENT-1:0] dv,
    output logic [AW-1:0]    e_addr [NUM_ENT],
    output logic [BW-1:0]    e_be   [NUM_ENT],
    output logic [DW-1:0]    e_data [NUM_ENT]
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
            sen <= '0;
            av  <= '0;
            dv  <= '0;
            for (int i = 0; i < NUM_ENT; i++) begin
                e_addr[i] <= '0;
                e_be[i]   <= '0;
                e_data[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_ENT; i++) begin
                if (alloc_en && alloc_pos == IW'(i)) begin
                    vld[i] <= 1'b1;
                    sen[i] <= 1'b0;
                    av[i]  <= 1'b0;
                    dv[i]  <= 1'b0;
                end else if (free_en && free_pos == IW'(i)) begin
                    vld[i] <= 1'b0;
                    sen[i] <= 1'b0;
                end else if (retire_en && retire_pos == IW'(i)) begin
                    sen[i] <= 1'b1;
                end else if (flush_en && !sen[i]) begin
                    vld[i] <= 1'b0;
                end
                if (addr_we && addr_pos == IW'(i)) begin
                    av[i]     <= 1'b1;
                    e_addr[i] <= addr_in;
                    e_be[i]   <= be_in;
                end
                if (data_we && data_pos == IW'(i)) begin
                    dv[i]     <= 1'b1;
                    e_data[i] <= data_in;
                end
            end
        end
    end
endmodule

// File: rtl/sob_ldchk.sv
module sob_ldchk
    import sob_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int AW = 16,
    parameter int DW = 32,
    localparam int IW = $clog2(NUM_ENT),
    localparam int BW = DW / 8
) (
    input  logic [IW:0]        head,
    input  logic [IW:0]        tag,
    input  logic [AW-1:0]      ld_addr,
    input  logic [BW-1:0]      ld_be,
    input  logic [NUM_ENT-1:0] vld,
    input  logic [NUM_ENT-1:0] av,
    input  logic [NUM_ENT-1:0] dv,
    input  logic [AW-1:0]      e_addr [NUM_ENT],
    input  logic [BW-1:0]      e_be   [NUM_ENT],
    input  logic [DW-1:0]      e_data [NUM_ENT],
    output rsp_kind_e          kind,
    output blk_cause_e         cause,
    output logic [IW-1:0]      blk_pos,
    output logic [DW-1:0]      fwd_data
);
    logic [IW:0]   lim;
    logic          in_rng;
    logic [IW-1:0] pos;
    logic          unres;
    logic [IW-1:0] unres_pos;
    logic          hit;
    logic [IW-1:0] hit_pos;

    always_comb begin
        lim       = tag + (IW+1)'(1) - head;
        in_rng    = (lim <= (IW+1)'(NUM_ENT));
        pos       = '0;
        unres     = 1'b0;
        unres_pos = '0;
        hit       = 1'b0;
        hit_pos   = '0;
        // oldest to youngest: keep the first unresolved, the last match
        for (int r = 0; r < NUM_ENT; r++) begin
            pos = head[IW-1:0] + IW'(r);
            if (in_rng && ((IW+1)'(r) < lim) && vld[pos]) begin
                if (!av[pos]) begin
                    if (!unres) begin
                        unres     = 1'b1;
                        unres_pos = pos;
                    end
                end else if (e_addr[pos] == ld_addr && |(e_be[pos] & ld_be)) begin
                    hit     = 1'b1;
                    hit_pos = pos;
                end
            end
        end

        kind     = RSP_CACHE;
        cause    = CS_NONE;
        blk_pos  = '0;
        fwd_data = '0;
        if (unres) begin
            kind    = RSP_BLOCK;
            cause   = CS_ADDR;
            blk_pos = unres_pos;
        end else if (hit) begin
            if (!dv[hit_pos]) begin
                kind    = RSP_BLOCK;
                cause   = CS_DATA;
                blk_pos = hit_pos;
            end else if ((ld_be & ~e_be[hit_pos]) != '0) begin
                kind    = RSP_BLOCK;
                cause   = CS_PART;
                blk_pos = hit_pos;
            end else begin
                kind     = RSP_FWD;
                fwd_data = e_data[hit_pos];
            end
        end
    end
endmodule

// File: rtl/sob_drain.sv
module sob_drain
    import sob_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic have_senior,
    input  logic cache_idle,
    output logic wr_fire
);
    drain_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DRAIN_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DRAIN_IDLE:  st_d = (have_senior && cache_idle) ? DRAIN_WRITE : DRAIN_IDLE;
            DRAIN_WRITE: st_d = DRAIN_IDLE;
            default:     st_d = DRAIN_IDLE;
        endcase
    end

    always_comb begin
        wr_fire = (st_q == DRAIN_WRITE);
    end
endmodule

// File: rtl/store_order_buf.sv
module store_order_buf
    import sob_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int IW = $clog2(NUM_ENT),
    localparam int BW = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_alloc,
    output logic [IW:0]       st_alloc_tag,
    output logic              st_full,
    input  logic              st_addr_valid,
    input  logic [IW-1:0]     st_addr_idx,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [BW-1:0]     st_be,
    input  logic              st_data_valid,
    input  logic [IW-1:0]     st_data_idx,
    input  logic [DATA_W-1:0] st_data,
    input  logic              st_retire,
    input  logic              flush,
    input  logic              ld_valid,
    input  logic [IW:0]       ld_tag,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [BW-1:0]     ld_be,
    output logic              ld_rsp_valid,
    output logic [1:0]        ld_rsp_kind,
    output logic [1:0]        ld_rsp_cause,
    output logic [IW-1:0]     ld_rsp_idx,
    output logic [DATA_W-1:0] ld_rsp_data,
    output logic              wake_addr_valid,
    output logic [IW-1:0]     wake_addr_idx,
    output logic              wake_data_valid,
    output logic [IW-1:0]     wake_data_idx,
    output logic              wake_free_valid,
    output logic [IW-1:0]     wake_free_idx,
    input  logic              cache_idle,
    output logic              cache_wr_valid,
    output logic [ADDR_W-1:0] cache_wr_addr,
    output logic [BW-1:0]     cache_wr_be,
    output logic [DATA_W-1:0] cache_wr_data
);
    logic [IW:0] head, sen_ptr, tail;
    logic [NUM_ENT-1:0] vld, sen, av, dv;
    logic [ADDR_W-1:0]  e_addr [NUM_ENT];
    logic [BW-1:0]      e_be   [NUM_ENT];
    logic [DATA_W-1:0]  e_data [NUM_ENT];
    logic do_alloc, do_retire, wr_fire;
    rsp_kind_e  chk_kind;
    blk_cause_e chk_cause;
    logic [IW-1:0]     chk_pos;
    logic [DATA_W-1:0] chk_data;

    assign st_full      = ((tail - head) == (IW+1)'(NUM_ENT));
    assign st_alloc_tag = tail;
    assign do_alloc     = st_alloc && !st_full && !flush;
    assign do_retire    = st_retire && (sen_ptr != tail);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head    <= '0;
            sen_ptr <= '0;
            tail    <= '0;
        end else begin
            head    <= head + (IW+1)'(wr_fire);
            sen_ptr <= sen_ptr + (IW+1)'(do_retire);
            tail    <= flush ? sen_ptr + (IW+1)'(do_retire) : tail + (IW+1)'(do_alloc);
        end
    end

    sob_entries #(.NUM_ENT(NUM_ENT), .AW(ADDR_W), .DW(DATA_W)) u_ent (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(do_alloc), .alloc_pos(tail[IW-1:0]),
        .addr_we(st_addr_valid), .addr_pos(st_addr_idx), .addr_in(st_addr), .be_in(st_be),
        .data_we(st_data_valid), .data_pos(st_data_idx), .data_in(st_data),
        .retire_en(do_retire), .retire_pos(sen_ptr[IW-1:0]),
        .free_en(wr_fire), .free_pos(head[IW-1:0]),
        .flush_en(flush),
        .vld(vld), .sen(sen), .av(av), .dv(dv),
        .e_addr(e_addr), .e_be(e_be), .e_data(e_data)
    );

    sob_ldchk #(.NUM_ENT(NUM_ENT), .AW(ADDR_W), .DW(DATA_W)) u_chk_ld (
        .head(head), .tag(ld_tag), .ld_addr(ld_addr), .ld_be(ld_be),
        .vld(vld), .av(av), .dv(dv),
        .e_addr(e_addr), .e_be(e_be), .e_data(e_data),
        .kind(chk_kind), .cause(chk_cause), .blk_pos(chk_pos), .fwd_data(chk_data)
    );

    sob_drain u_drain (
        .clk(clk), .rst_n(rst_n),
        .have_senior(head != sen_ptr),
        .cache_idle(cache_idle),
        .wr_fire(wr_fire)
    );

    assign cache_wr_valid = wr_fire;
    assign cache_wr_addr  = wr_fire ? e_addr[head[IW-1:0]] : '0;
    assign cache_wr_be    = wr_fire ? e_be[head[IW-1:0]]   : '0;
    assign cache_wr_data  = wr_fire ? e_data[head[IW-1:0]] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_rsp_valid    <= 1'b0;
            ld_rsp_kind     <= RSP_CACHE;
            ld_rsp_cause    <= CS_NONE;
            ld_rsp_idx      <= '0;
            ld_rsp_data     <= '0;
            wake_addr_valid <= 1'b0;
            wake_addr_idx   <= '0;
            wake_data_valid <= 1'b0;
            wake_data_idx   <= '0;
            wake_free_valid <= 1'b0;
            wake_free_idx   <= '0;
        end else begin
            ld_rsp_valid    <= ld_valid;
            ld_rsp_kind     <= ld_valid ? chk_kind  : RSP_CACHE;
            ld_rsp_cause    <= ld_valid ? chk_cause : CS_NONE;
            ld_rsp_idx      <= ld_valid ? chk_pos   : '0;
            ld_rsp_data     <= ld_valid ? chk_data  : '0;
            wake_addr_valid <= st_addr_valid;
            wake_addr_idx   <= st_addr_idx;
            wake_data_valid <= st_data_valid;
            wake_data_idx   <= st_data_idx;
            wake_free_valid <= wr_fire;
            wake_free_idx   <= head[IW-1:0];
        end
    end
endmodule

// File: rtl/store_order_buf_chk.sv
module store_order_buf_chk #(
    parameter int NUM_ENT = 8,
    localparam int IW = $clog2(NUM_ENT)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_alloc,
    input logic [IW:0]   st_alloc_tag,
    input logic          st_full,
    input logic          flush,
    input logic          st_addr_valid,
    input logic [IW-1:0] st_addr_idx,
    input logic          st_data_valid,
    input logic [IW-1:0] st_data_idx,
    input logic          ld_valid,
    input logic          ld_rsp_valid,
    input logic [1:0]    ld_rsp_kind,
    input logic [1:0]    ld_rsp_cause,
    input logic          wake_addr_valid,
    input logic [IW-1:0] wake_addr_idx,
    input logic          wake_data_valid,
    input logic [IW-1:0] wake_data_idx,
    input logic          cache_idle,
    input logic          cache_wr_valid
);
    AST_FULL_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (st_full && st_alloc && !flush) |=> $stable(st_alloc_tag)); // R2
    AST_BLOCK_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_rsp_valid && ld_rsp_kind == 2'd2) |-> (ld_rsp_cause != 2'd0)); // R4
    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> ld_rsp_valid); // R6
    AST_PASS_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_rsp_valid && ld_rsp_kind != 2'd2) |-> (ld_rsp_cause == 2'd0)); // R8
    AST_WAKE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        st_addr_valid |=> (wake_addr_valid && wake_addr_idx == $past(st_addr_idx))); // R9
    AST_WAKE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        st_data_valid |=> (wake_data_valid && wake_data_idx == $past(st_data_idx))); // R9
    AST_DRAIN_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cache_wr_valid) |-> $past(cache_idle)); // R12
    AST_DRAIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cache_wr_valid |=> !cache_wr_valid); // R12
endmodule

bind store_order_buf store_order_buf_chk #(.NUM_ENT(NUM_ENT)) u_sob_chk (.*);

// File: tb/store_order_buf_test.sv
`timescale 1ns/1ps
module store_order_buf_test;
    localparam int NE = 8;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int IW = 3;
    localparam int BW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_alloc = 0, st_addr_valid = 0, st_data_valid = 0, st_retire = 0, flush = 0;
    logic ld_valid = 0, cache_idle = 0;
    logic [IW-1:0] st_addr_idx = '0, st_data_idx = '0;
    logic [AW-1:0] st_addr = '0, ld_addr = '0;
    logic [BW-1:0] st_be = '0, ld_be = '0;
    logic [DW-1:0] st_data = '0;
    logic [IW:0]   ld_tag = '0;
    logic [IW:0]   st_alloc_tag;
    logic          st_full, ld_rsp_valid;
    logic [1:0]    ld_rsp_kind, ld_rsp_cause;
    logic [IW-1:0] ld_rsp_idx, wake_addr_idx, wake_data_idx, wake_free_idx;
    logic [DW-1:0] ld_rsp_data, cache_wr_data;
    logic          wake_addr_valid, wake_data_valid, wake_free_valid, cache_wr_valid;
    logic [AW-1:0] cache_wr_addr;
    logic [BW-1:0] cache_wr_be;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    store_order_buf #(.NUM_ENT(NE), .ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .st_alloc(st_alloc), .st_alloc_tag(st_alloc_tag), .st_full(st_full),
        .st_addr_valid(st_addr_valid), .st_addr_idx(st_addr_idx), .st_addr(st_addr), .st_be(st_be),
        .st_data_valid(st_data_valid), .st_data_idx(st_data_idx), .st_data(st_data),
        .st_retire(st_retire), .flush(flush),
        .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr), .ld_be(ld_be),
        .ld_rsp_valid(ld_rsp_valid), .ld_rsp_kind(ld_rsp_kind), .ld_rsp_cause(ld_rsp_cause),
        .ld_rsp_idx(ld_rsp_idx), .ld_rsp_data(ld_rsp_data),
        .wake_addr_valid(wake_addr_valid), .wake_addr_idx(wake_addr_idx),
        .wake_data_valid(wake_data_valid), .wake_data_idx(wake_data_idx),
        .wake_free_valid(wake_free_valid), .wake_free_idx(wake_free_idx),
        .cache_idle(cache_idle), .cache_wr_valid(cache_wr_valid),
        .cache_wr_addr(cache_wr_addr), .cache_wr_be(cache_wr_be), .cache_wr_data(cache_wr_data)
    );

    // tag | addr | be | kind | cause | idx | data
    localparam logic [62:0] TBL [9] = '{
        {4'd0, 16'h0010, 4'hF, 2'd1, 2'd0, 3'd0, 32'hA0A0A0A0}, // R6 full cover
        {4'd0, 16'h0030, 4'hF, 2'd0, 2'd0, 3'd0, 32'h0},        // R8 no match
        {4'd1, 16'h0020, 4'h1, 2'd2, 2'd2, 3'd1, 32'h0},        // R5 data missing
        {4'd2, 16'h0010, 4'h3, 2'd1, 2'd0, 3'd0, 32'h11112222}, // R6 nearest store
        {4'd2, 16'h0010, 4'hF, 2'd2, 2'd3, 3'd2, 32'h0},        // R7 partial
        {4'd2, 16'h0010, 4'hC, 2'd1, 2'd0, 3'd0, 32'hA0A0A0A0}, // R5 skip non-overlap
        {4'd3, 16'h0040, 4'hF, 2'd2, 2'd1, 3'd3, 32'h0},        // R4 unresolved
        {4'd1, 16'h0010, 4'h3, 2'd1, 2'd0, 3'd0, 32'hA0A0A0A0}, // R3 younger ignored
        {4'hF, 16'h0010, 4'hF, 2'd0, 2'd0, 3'd0, 32'h0}         // R3 tag before head
    };
    localparam int TREQ [9] = '{6, 8, 5, 6, 7, 5, 4, 3, 3};

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_alloc();
        st_alloc = 1; @(negedge clk); st_alloc = 0;
    endtask

    task automatic wr_addr(input logic [IW-1:0] i, input logic [AW-1:0] a, input logic [BW-1:0] b);
        st_addr_valid = 1; st_addr_idx = i; st_addr = a; st_be = b;
        @(negedge clk); st_addr_valid = 0;
    endtask

    task automatic wr_data(input logic [IW-1:0] i, input logic [DW-1:0] d);
        st_data_valid = 1; st_data_idx = i; st_data = d;
        @(negedge clk); st_data_valid = 0;
    endtask

    task automatic load(input logic [IW:0] t, input logic [AW-1:0] a, input logic [BW-1:0] b);
        ld_valid = 1; ld_tag = t; ld_addr = a; ld_be = b;
        @(negedge clk); ld_valid = 0;
    endtask

    task automatic pulse_retire();
        st_retire = 1; @(negedge clk); st_retire = 0;
    endtask

    task automatic pulse_flush();
        flush = 1; @(negedge clk); flush = 0;
    endtask

    logic [AW-1:0] wa [4];
    logic [BW-1:0] wb [4];
    logic [DW-1:0] wd [4];
    logic [IW-1:0] wf [4];
    int n_wr, n_fr;

    task automatic drain_watch(input int cycles);
        n_wr = 0; n_fr = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (cache_wr_valid && n_wr < 4) begin
                wa[n_wr] = cache_wr_addr; wb[n_wr] = cache_wr_be; wd[n_wr] = cache_wr_data; n_wr++;
            end
            if (wake_free_valid && n_fr < 4) begin
                wf[n_fr] = wake_free_idx; n_fr++;
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int wr_quiet;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "full", st_full, 0);
        chk("R1", "tag", st_alloc_tag, 0);
        chk("R1", "rsp", ld_rsp_valid, 0);
        chk("R1", "wakes", {wake_addr_valid, wake_data_valid, wake_free_valid, cache_wr_valid}, 0);
        rst_n = 1;
        @(negedge clk);

        // R2 in-order indices
        for (int k = 0; k < 4; k++) begin
            chk("R2", "alloc tag", st_alloc_tag, k);
            do_alloc();
        end

        // R9 data before address on slot 0
        wr_data(3'd0, 32'hA0A0A0A0);
        chk("R9", "data wake", {wake_data_valid, wake_data_idx}, {1'b1, 3'd0});
        load(4'd0, 16'h0010, 4'hF);
        chk("R4", "kind", ld_rsp_kind, 2);
        chk("R4", "cause", ld_rsp_cause, 1);
        wr_addr(3'd0, 16'h0010, 4'hF);
        chk("R9", "addr wake", {wake_addr_valid, wake_addr_idx}, {1'b1, 3'd0});
        wr_addr(3'd1, 16'h0020, 4'h3);
        wr_addr(3'd2, 16'h0010, 4'h3);
        wr_data(3'd2, 32'h11112222);

        for (int k = 0; k < 9; k++) begin
            logic [62:0] v;
            string rq;
            v = TBL[k];
            rq = $sformatf("R%0d", TREQ[k]);
            load(v[62:59], v[58:43], v[42:39]);
            chk(rq, "valid", ld_rsp_valid, 1);
            chk(rq, "kind", ld_rsp_kind, v[38:37]);
            chk(rq, "cause", ld_rsp_cause, v[36:35]);
            if (v[38:37] == 2'd2) chk(rq, "idx", ld_rsp_idx, v[34:32]);
            if (v[38:37] == 2'd1) chk(rq, "data", ld_rsp_data, v[31:0]);
        end

        // R9 address of slot 3 arrives, load now waits on data
        wr_addr(3'd3, 16'h0040, 4'hF);
        chk("R9", "addr wake 3", {wake_addr_valid, wake_addr_idx}, {1'b1, 3'd3});
        load(4'd3, 16'h0040, 4'hF);
        chk("R5", "kind after addr", {ld_rsp_kind, ld_rsp_cause, ld_rsp_idx}, {2'd2, 2'd2, 3'd3});
        wr_data(3'd1, 32'h0000BEEF);
        chk("R9", "data wake 1", {wake_data_valid, wake_data_idx}, {1'b1, 3'd1});
        load(4'd1, 16'h0020, 4'h1);
        chk("R6", "reissued fwd", {ld_rsp_kind, ld_rsp_data}, {2'd1, 32'h0000BEEF});
        wr_data(3'd3, 32'h33333333);

        // R12 no drain while port busy
        pulse_retire();
        pulse_retire();
        wr_quiet = 0;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            if (cache_wr_valid) wr_quiet++;
        end
        chk("R12", "write while busy", wr_quiet, 0);

        // R10 drain in order
        cache_idle = 1;
        drain_watch(10);
        cache_idle = 0;
        chk("R10", "write count", n_wr, 2);
        chk("R10", "first write", {wa[0], wb[0], wd[0]}, {16'h0010, 4'hF, 32'hA0A0A0A0});
        chk("R10", "second write", {wa[1], wb[1], wd[1]}, {16'h0020, 4'h3, 32'h0000BEEF});
        chk("R10", "free wakes", {n_fr[3:0], wf[0], wf[1]}, {4'd2, 3'd0, 3'd1});

        // R11 flush keeps retired slot 2, drops slot 3
        pulse_retire();
        pulse_flush();
        chk("R11", "tag after flush", st_alloc_tag, 3);
        load(4'd2, 16'h0010, 4'h3);
        chk("R11", "senior fwd", {ld_rsp_kind, ld_rsp_data}, {2'd1, 32'h11112222});
        load(4'd3, 16'h0040, 4'hF);
        chk("R11", "dropped store", {ld_rsp_kind, ld_rsp_cause}, {2'd0, 2'd0});
        cache_idle = 1;
        drain_watch(8);
        cache_idle = 0;
        chk("R11", "senior drained", {n_wr[3:0], wa[0], wd[0]}, {4'd1, 16'h0010, 32'h11112222});

        // R2 fill from head 3 and overflow
        for (int k = 0; k < NE; k++) do_alloc();
        chk("R2", "full", st_full, 1);
        chk("R2", "tag at full", st_alloc_tag, 4'hB);
        do_alloc();
        chk("R2", "tag after ignored alloc", st_alloc_tag, 4'hB);
        pulse_flush();
        chk("R11", "flush empties", {st_full, st_alloc_tag}, {1'b0, 4'd3});

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule